// File: doc/BRIEF.md
# Protected two-level pin multiplexer

This block holds the pin configuration for a bank of configurable pads and turns it into per-pin control outputs. It sits on a simple 32-bit register port and has two register banks at separate base addresses. Each bank has one configuration word per pin and a protect register. The second bank also has two registers that pick a source for each of the two management-data channels.

A pin's first-level word carries its pull setting, its drive-strength code and a function code. The values 0 to 9 pick a function directly. The value 15 passes the choice to the pin's second-level word, which names one of 62 further functions. For every pin the block drives a registered compound function number, the pull code, the drive code and a high-impedance flag. For each channel it drives the chosen source index.

Writes to either bank are refused until software opens that bank. It opens the bank by writing the protect register's own bus address, with bit 0 set, into that register. Writing the same address with bit 0 clear closes the bank again. Any other value written to the protect register has no effect.

Top module: `pinmux_ctrl`

## Requirements
- R1: After reset both banks are locked, every stored word reads 0, every pin outputs function 0, pull 0 and drive 0 with its high-impedance flag set, and both channel sources are 0.
- R2: The protect register is at byte offset 0x400 of its bank. Writing it with bits [31:1] equal to that register's own byte address [31:1] sets the bank's lock state from bit 0, where 1 means unlocked. A read of it returns that state in bit 0, with all other bits 0.
- R3: A protect-register write whose bits [31:1] differ from the register's own address leaves the lock state unchanged.
- R4: While a bank is locked, writes to its pin words and channel-select registers are ignored. Reads always return the stored values.
- R5: A first-level pin word at byte offset 4*pin stores the function code in bits [3:0], the pull code in bits [9:8] and the drive code in bits [11:10]. The pull encoding is 0 none, 1 up, 3 down. The drive encoding is 0, 1, 2 and 3 for 4, 6, 8 and 12 mA. The other bits read as 0. Pull and drive appear unchanged on the pin's outputs.
- R6: The output function is the first-level code when that code is 0 to 9. It is 10 plus the second-level value (bits [5:0] of the second-level word) when the first-level code is 15 and that value is at most 61. It is 127 for first-level codes 10 to 14 and for second-level values 62 and 63.
- R7: The high-impedance flag is set when the first-level code is 0, or when the first-level code is 15 and the second-level value is 0. In all other cases it is clear.
- R8: Channel 0 and channel 1 source registers sit at byte offsets 0x404 and 0x408 of the second bank. Each stores bits [2:0]: 0 is high impedance and 1 to 7 are internal sources. Each drives its 3-bit slice of the channel output, channel 0 in the low bits.
- R9: A pin's outputs change on the second clock edge after an accepted write is presented, one edge after the storage edge. Read data appears on the edge that samples the read request.
- R10: Each bank's lock is independent: opening or closing one bank does not change the other.
- R11: Words at pin offsets at or above the pin count, and any other unmapped offsets, ignore writes and read as 0. The last pin (index 169 by default) behaves like every other pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_i | input | 1 | Write request for this cycle |
| bus_rd_i | input | 1 | Read request for this cycle |
| bus_addr_i | input | 32 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| pin_func_o | output | 7*NUM_PINS | Compound function number per pin, pin 0 in the low bits |
| pin_pull_o | output | 2*NUM_PINS | Pull code per pin |
| pin_drive_o | output | 2*NUM_PINS | Drive-strength code per pin |
| pin_hiz_o | output | NUM_PINS | High-impedance flag per pin |
| mdio_src_o | output | 6 | Source index per management channel, channel 0 in bits [2:0] |

## Verification
The hardest state to reach is a pin whose function depends on both banks. Its first-level word must hold 15 and its second-level word must hold a boundary value such as 0, 61 or 62. The two banks are opened one at a time, so the stimulus has to open the right bank before each write. Directed steps open the first bank alone, set the hand-over code and then show that a write to the still-locked second bank does nothing. After that they open the second bank and step its value across the 0/61/62 edges. The random phase forces code 15 on half of its first-level writes and mixes correct and corrupted key writes into the traffic. As a result, locked and unlocked writes to each bank occur throughout the run.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int FN_W   = 7;
  localparam int L2_W   = 6;
  localparam int MSRC_W = 3;
  localparam int N_MDIO = 2;

  localparam logic [3:0]      L1_DIRECT_MAX = 4'd9;
  localparam logic [3:0]      L1_TO_L2      = 4'd15;
  localparam logic [3:0]      HIZ_FSEL      = 4'd0;
  localparam logic [L2_W-1:0] L2_MAX        = 6'd61;
  localparam logic [FN_W-1:0] L2_OFFSET     = 7'd10;
  localparam logic [FN_W-1:0] FN_RSV        = 7'h7F;

  localparam logic [8:0] PROT_WIDX  = 9'h100;
  localparam logic [8:0] MDIO_WIDX0 = 9'h101;

  typedef struct packed {
    logic [1:0] drive;
    logic [1:0] pull;
    logic [3:0] fsel;
  } l1_cfg_t;
endpackage

// File: rtl/pinmux_bank_lock.sv
module pinmux_bank_lock #(
  parameter logic [31:0] KEY = 32'h0000_0400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr_i,
  input  logic [31:0] wdata_i,
  output logic        unlocked_o
);
  logic unl_d, unl_q;

  always_comb begin
    unl_d = unl_q;
    if (key_wr_i && (wdata_i[31:1] == KEY[31:1])) unl_d = wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unl_q <= 1'b0;
    else        unl_q <= unl_d;
  end

  assign unlocked_o = unl_q;
endmodule

// File: rtl/pinmux_pin_resolve.sv
module pinmux_pin_resolve
  import pinmux_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  l1_cfg_t         l1_i,
  input  logic [L2_W-1:0] l2_i,
  output logic [FN_W-1:0] func_o,
  output logic [1:0]      pull_o,
  output logic [1:0]      drive_o,
  output logic            hiz_o
);
  logic [FN_W-1:0] func_d, func_q;
  logic            hiz_d, hiz_q;
  logic [1:0]      pull_q, drive_q;

  always_comb begin
    if (l1_i.fsel <= L1_DIRECT_MAX)
      func_d = FN_W'(l1_i.fsel);
    else if (l1_i.fsel == L1_TO_L2)
      func_d = (l2_i <= L2_MAX) ? (FN_W'(l2_i) + L2_OFFSET) : FN_RSV;
    else
      func_d = FN_RSV;
    hiz_d = (l1_i.fsel == HIZ_FSEL) ||
            ((l1_i.fsel == L1_TO_L2) && (l2_i == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q  <= '0;
      hiz_q   <= 1'b1;
      pull_q  <= '0;
      drive_q <= '0;
    end else begin
      func_q  <= func_d;
      hiz_q   <= hiz_d;
      pull_q  <= l1_i.pull;
      drive_q <= l1_i.drive;
    end
  end

  assign func_o  = func_q;
  assign hiz_o   = hiz_q;
  assign pull_o  = pull_q;
  assign drive_o = drive_q;
endmodule

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
  import pinmux_pkg::*;
#(
  parameter int          NUM_PINS = 170,
  parameter logic [31:0] L1_BASE  = 32'h5000_0000,
  parameter logic [31:0] L2_BASE  = 32'h5000_0800
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr_i,
  input  logic                       bus_rd_i,
  input  logic [31:0]                bus_addr_i,
  input  logic [31:0]                bus_wdata_i,
  output logic [31:0]                bus_rdata_o,
  output logic [FN_W*NUM_PINS-1:0]   pin_func_o,
  output logic [2*NUM_PINS-1:0]      pin_pull_o,
  output logic [2*NUM_PINS-1:0]      pin_drive_o,
  output logic [NUM_PINS-1:0]        pin_hiz_o,
  output logic [MSRC_W*N_MDIO-1:0]   mdio_src_o
);
  localparam int          PIDX_W  = $clog2(NUM_PINS);
  localparam logic [8:0]  NPINS_W = 9'(NUM_PINS);
  localparam logic [31:0] KEY1    = L1_BASE + 32'h400;
  localparam logic [31:0] KEY2    = L2_BASE + 32'h400;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // address decode
  logic              hit1, hit2, conf_sel;
  logic [8:0]        widx;
  logic [PIDX_W-1:0] pidx;
  logic [1:0]        key_wr, unl;
  logic              we_l1, we_l2;
  logic [N_MDIO-1:0] we_md;

  assign hit1     = bus_addr_i[31:11] == L1_BASE[31:11];
  assign hit2     = bus_addr_i[31:11] == L2_BASE[31:11];
  assign widx     = bus_addr_i[10:2];
  assign pidx     = widx[PIDX_W-1:0];
  assign conf_sel = widx < NPINS_W;
  assign key_wr   = {bus_wr_i && hit2 && (widx == PROT_WIDX),
                     bus_wr_i && hit1 && (widx == PROT_WIDX)};
  assign we_l1    = bus_wr_i && hit1 && unl[0] && conf_sel;
  assign we_l2    = bus_wr_i && hit2 && unl[1] && conf_sel;

  for (genvar k = 0; k < N_MDIO; k++) begin : g_mdio_we
    assign we_md[k] = bus_wr_i && hit2 && unl[1] && (widx == MDIO_WIDX0 + 9'(k));
  end

  pinmux_bank_lock #(.KEY(KEY1)) u_lock1 (
    .clk(clk), .rst_n(rst_sync_n), .key_wr_i(key_wr[0]),
    .wdata_i(bus_wdata_i), .unlocked_o(unl[0]));
  pinmux_bank_lock #(.KEY(KEY2)) u_lock2 (
    .clk(clk), .rst_n(rst_sync_n), .key_wr_i(key_wr[1]),
    .wdata_i(bus_wdata_i), .unlocked_o(unl[1]));

  // storage: next-state
  l1_cfg_t           l1_q [NUM_PINS];
  l1_cfg_t           l1_d [NUM_PINS];
  logic [L2_W-1:0]   l2_q [NUM_PINS];
  logic [L2_W-1:0]   l2_d [NUM_PINS];
  logic [MSRC_W-1:0] md_q [N_MDIO];
  logic [MSRC_W-1:0] md_d [N_MDIO];

  always_comb begin
    l1_d = l1_q;
    l2_d = l2_q;
    md_d = md_q;
    if (we_l1) l1_d[pidx] = '{drive: bus_wdata_i[11:10], pull: bus_wdata_i[9:8],
                              fsel: bus_wdata_i[3:0]};
    if (we_l2) l2_d[pidx] = bus_wdata_i[L2_W-1:0];
    for (int k = 0; k < N_MDIO; k++)
      if (we_md[k]) md_d[k] = bus_wdata_i[MSRC_W-1:0];
  end

  // storage: registers with write enables
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        l1_q[i] <= '0;
        l2_q[i] <= '0;
      end
      for (int k = 0; k < N_MDIO; k++) md_q[k] <= '0;
    end else begin
      if (we_l1) l1_q <= l1_d;
      if (we_l2) l2_q <= l2_d;
      if (|we_md) md_q <= md_d;
    end
  end

  // read path
  logic [31:0] rd_d, rd_q;
  always_comb begin
    rd_d = '0;
    if (hit1) begin
      if (conf_sel)
        rd_d = {20'b0, l1_q[pidx].drive, l1_q[pidx].pull, 4'b0, l1_q[pidx].fsel};
      else if (widx == PROT_WIDX)
        rd_d = {31'b0, unl[0]};
    end else if (hit2) begin
      if (conf_sel)
        rd_d = {{(32-L2_W){1'b0}}, l2_q[pidx]};
      else if (widx == PROT_WIDX)
        rd_d = {31'b0, unl[1]};
      else
        for (int k = 0; k < N_MDIO; k++)
          if (widx == MDIO_WIDX0 + 9'(k)) rd_d = {{(32-MSRC_W){1'b0}}, md_q[k]};
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   rd_q <= '0;
    else if (bus_rd_i) rd_q <= rd_d;
  end
  assign bus_rdata_o = rd_q;

  // per-pin resolution
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pinmux_pin_resolve u_res (
      .clk(clk), .rst_n(rst_sync_n), .l1_i(l1_q[p]), .l2_i(l2_q[p]),
      .func_o(pin_func_o[p*FN_W +: FN_W]), .pull_o(pin_pull_o[p*2 +: 2]),
      .drive_o(pin_drive_o[p*2 +: 2]), .hiz_o(pin_hiz_o[p]));
  end

  for (genvar k = 0; k < N_MDIO; k++) begin : g_mdio_out
    assign mdio_src_o[k*MSRC_W +: MSRC_W] = md_q[k];
  end
endmodule

// File: rtl/pinmux_ctrl_chk.sv
module pinmux_ctrl_chk #(
  parameter logic [31:0] KEY1 = 32'h5000_0400,
  parameter logic [31:0] KEY2 = 32'h5000_0C00
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  unl,
  input logic [1:0]  key_wr,
  input logic        bus_rd_i,
  input logic [31:0] bus_addr_i,
  input logic [31:0] bus_wdata_i,
  input logic [31:0] bus_rdata_o,
  input logic [6:0]  pin0_func,
  input logic        pin0_hiz,
  input logic [5:0]  mdio_src_o
);
  // R2: correct key with bit 0 set opens the bank
  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr[0] && bus_wdata_i == (KEY1 | 32'h1)) |=> unl[0]);
  // R2: correct key with bit 0 clear closes the bank
  p_lock_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr[1] && bus_wdata_i == KEY2) |=> !unl[1]);
  // R2: protect read returns lock state only
  p_prot_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == KEY1) |=> (bus_rdata_o == {31'b0, $past(unl[0])}));
  // R3: wrong key leaves lock state unchanged
  p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr[0] && bus_wdata_i[31:1] != KEY1[31:1]) |=> (unl[0] == $past(unl[0])));
  // R4: with both banks locked for two samples, outputs hold
  p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (unl == 2'b00 && $past(unl) == 2'b00) |=> ($stable(pin0_func) && $stable(mdio_src_o)));
  // R6: function number is a legal compound value or the reserved code
  p_func_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin0_func <= 7'd71) || (pin0_func == 7'h7F));
  // R7: high-impedance flag agrees with functions 0 and 10
  p_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pin0_hiz == ((pin0_func == 7'd0) || (pin0_func == 7'd10)));
  // R10: a key write to bank 1 never moves bank 2
  p_bank_indep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr[0] && !key_wr[1]) |=> (unl[1] == $past(unl[1])));
endmodule

bind pinmux_ctrl pinmux_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .unl(unl), .key_wr(key_wr),
  .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o), .pin0_func(pin_func_o[6:0]), .pin0_hiz(pin_hiz_o[0]),
  .mdio_src_o(mdio_src_o));

// File: tb/sim_pinmux_ctrl.sv
`timescale 1ns/1ps
module sim_pinmux_ctrl;
  localparam int          NP = 170;
  localparam logic [31:0] B1 = 32'h5000_0000;
  localparam logic [31:0] B2 = 32'h5000_0800;
  localparam logic [31:0] P1 = 32'h5000_0400;
  localparam logic [31:0] P2 = 32'h5000_0C00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [31:0] addr = '0, wdata = '0, rdata;
  logic [7*NP-1:0] pfunc;
  logic [2*NP-1:0] ppull, pdrive;
  logic [NP-1:0]   phiz;
  logic [5:0]      msrc;

  always #4 clk = ~clk;

  pinmux_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_func_o(pfunc), .pin_pull_o(ppull),
    .pin_drive_o(pdrive), .pin_hiz_o(phiz), .mdio_src_o(msrc));

  int checks = 0, errors = 0;

  // bench model
  logic [3:0] m_fs [NP];
  logic [1:0] m_pu [NP];
  logic [1:0] m_dr [NP];
  logic [5:0] m_l2 [NP];
  logic [2:0] m_md [2];
  logic       m_unl [2];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_func(input logic [3:0] f, input logic [5:0] s);
    if (f <= 9) return int'(f);
    if (f == 15) return (s <= 61) ? 10 + int'(s) : 127;
    return 127;
  endfunction

  function automatic int exp_hiz(input logic [3:0] f, input logic [5:0] s);
    return ((f == 0) || (f == 15 && s == 0)) ? 1 : 0;
  endfunction

  function automatic void model_write(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] base;
    logic [31:0] key;
    int w;
    for (int b = 0; b < 2; b++) begin
      base = (b == 0) ? B1 : B2;
      key  = (b == 0) ? P1 : P2;
      if (a[31:11] == base[31:11]) begin
        w = int'(a[10:2]);
        if (w == 256) begin
          if (d[31:1] == key[31:1]) m_unl[b] = d[0];
        end else if (m_unl[b]) begin
          if (w < NP) begin
            if (b == 0) begin
              m_fs[w] = d[3:0]; m_pu[w] = d[9:8]; m_dr[w] = d[11:10];
            end else m_l2[w] = d[5:0];
          end else if (b == 1 && (w == 257 || w == 258)) m_md[w-257] = d[2:0];
        end
      end
    end
  endfunction

  function automatic int exp_read(input logic [31:0] a);
    int w;
    w = int'(a[10:2]);
    if (a[31:11] == B1[31:11]) begin
      if (w < NP) return int'({20'b0, m_dr[w], m_pu[w], 4'b0, m_fs[w]});
      if (w == 256) return int'(m_unl[0]);
    end else if (a[31:11] == B2[31:11]) begin
      if (w < NP) return int'(m_l2[w]);
      if (w == 256) return int'(m_unl[1]);
      if (w == 257 || w == 258) return int'(m_md[w-257]);
    end
    return 0;
  endfunction

  // write: presented at a falling edge, taken on the next rising edge
  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic chk_read(input string req, input logic [31:0] a);
    logic [31:0] d;
    bus_read(a, d);
    chk(req, int'(d), exp_read(a));
  endtask

  task automatic chk_pin(input string req, input int p);
    chk(req, int'(pfunc[p*7 +: 7]), exp_func(m_fs[p], m_l2[p]));
    chk(req, int'(ppull[p*2 +: 2]), int'(m_pu[p]));
    chk(req, int'(pdrive[p*2 +: 2]), int'(m_dr[p]));
    chk(req, int'(phiz[p]), exp_hiz(m_fs[p], m_l2[p]));
  endtask

  // write a pin word, then let the output register take it
  task automatic pin_write(input logic [31:0] a, input logic [31:0] d);
    bus_write(a, d);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) begin
      m_fs[i] = '0; m_pu[i] = '0; m_dr[i] = '0; m_l2[i] = '0;
    end
    m_md[0] = '0; m_md[1] = '0; m_unl[0] = 1'b0; m_unl[1] = 1'b0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_read("R1 prot1", P1);
    chk_read("R1 prot2", P2);
    chk("R1 func0", int'(pfunc[6:0]), 0);
    chk("R1 hiz0", int'(phiz[0]), 1);
    chk("R1 mdio", int'(msrc), 0);
    chk_read("R1 conf", B1 + 32'd12);

    // R4 locked bank ignores writes
    pin_write(B1 + 32'd12, 32'h0000_0F05);
    chk_read("R4 locked l1 read", B1 + 32'd12);
    chk("R4 locked l1 out", int'(pfunc[3*7 +: 7]), 0);

    // R3 wrong key, R2 unlock, R10 independence
    bus_write(P1, 32'h5000_0501);
    chk_read("R3 wrong key", P1);
    bus_write(P1, P1 | 32'h1);
    chk_read("R2 unlock", P1);
    chk_read("R10 other bank", P2);

    // R5 fields and R9 timing
    bus_write(B1 + 32'd20, 32'hFFFF_FBA7);
    chk("R9 not yet", int'(pfunc[5*7 +: 7]), 0);
    @(negedge clk);
    chk("R9 updated", int'(pfunc[5*7 +: 7]), 7);
    chk_pin("R5 pin5", 5);
    chk_read("R5 readback", B1 + 32'd20);

    // R11 last pin and out of range
    pin_write(B1 + 32'd676, 32'h0000_0103);
    chk_pin("R11 pin169", 169);
    pin_write(B1 + 32'd680, 32'h0000_0005);
    chk_read("R11 offset170", B1 + 32'd680);
    chk_pin("R11 pin169 kept", 169);

    // R7 / R6 hand-over to level 2
    pin_write(B1 + 32'd32, 32'h0000_000F);
    chk("R7 hiz via l2=0", int'(phiz[8]), 1);
    chk("R6 func 10", int'(pfunc[8*7 +: 7]), 10);
    pin_write(B1 + 32'd32, 32'h0000_000C);
    chk("R6 reserved l1", int'(pfunc[8*7 +: 7]), 127);
    pin_write(B1 + 32'd32, 32'h0000_000F);
    pin_write(B2 + 32'd32, 32'h0000_003D);
    chk("R4 l2 locked", int'(pfunc[8*7 +: 7]), 10);
    bus_write(P2, P2 | 32'h1);
    chk_read("R10 l2 open", P2);
    pin_write(B2 + 32'd32, 32'h0000_003D);
    chk("R6 l2 61", int'(pfunc[8*7 +: 7]), 71);
    chk("R7 hiz clear", int'(phiz[8]), 0);
    pin_write(B2 + 32'd32, 32'h0000_003E);
    chk("R6 l2 62", int'(pfunc[8*7 +: 7]), 127);
    pin_write(B2 + 32'd32, 32'h0000_0000);
    chk_pin("R7 l2 zero", 8);

    // R8 channel selects
    bus_write(B2 + 32'h404, 32'h0000_0005);
    chk("R8 ch0", int'(msrc[2:0]), 5);
    bus_write(B2 + 32'h408, 32'hFFFF_FFFE);
    chk("R8 ch1", int'(msrc[5:3]), 6);
    chk_read("R8 ch1 read", B2 + 32'h408);

    // R2 lock again, R4 ignored afterwards
    bus_write(P1, P1);
    chk_read("R2 relock", P1);
    pin_write(B1 + 32'd20, 32'h0000_0002);
    chk_pin("R4 after relock", 5);
    bus_write(P2, P2);
    bus_write(B2 + 32'h404, 32'h0000_0001);
    chk("R4 mdio locked", int'(msrc[2:0]), 5);

    // random traffic
    for (int it = 0; it < 500; it++) begin
      int r, b, p;
      logic [31:0] d, base, key;
      r = int'($urandom % 10);
      b = int'($urandom % 2);
      base = (b == 0) ? B1 : B2;
      key  = (b == 0) ? P1 : P2;
      if (r < 2) begin
        d = key | 32'($urandom % 2);
        if ($urandom % 4 == 0) d = d ^ 32'h0000_0100;
        bus_write(key, d);
        chk_read("R2 R3 random lock", key);
      end else if (r < 8) begin
        p = int'($urandom % NP);
        d = $urandom;
        if ($urandom % 2 == 1) d[3:0] = 4'hF;
        pin_write(base + 32'(p * 4), d);
        chk_pin("R6 random pin", p);
        chk_read("R4 random read", base + 32'(p * 4));
      end else begin
        p = int'($urandom % 2);
        bus_write(B2 + 32'h404 + 32'(p * 4), $urandom);
        chk("R8 random mdio", int'(msrc[p*3 +: 3]), int'(m_md[p]));
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule